// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block is the digital configuration front end of a clock synthesizer. It holds three settings: a 9-bit feedback divide value M, a 3-bit output divide code N, and a 2-bit test selector. These settings drive the divider logic. The test selector steers one of four internal signals onto a single test pin. The PLL and the dividers themselves live elsewhere; this block only supplies their settings.

There are two ways to write the settings. The first is a parallel pin bank under a parallel strobe: it is transparent while the strobe is low and latched on its rising edge. The second is a three-wire serial port with data, clock and load. The serial clock, data, load and parallel strobe are all asynchronous to the system clock. Each passes through a synchronizer chain and an edge detector before it is used, so every load action happens on the system clock.

The serial load wire has three behaviours. Its rising edge copies the shift register into the settings. Its falling edge freezes them. While it stays high, every serial clock edge passes the freshly shifted word straight into the settings. A range flag reports when the current M lies outside the band in which the loop can lock.

Top module: `synth_cfg_port`

## Requirements
- R1: While `rst` is high, the test selector clears to 00 and M and N take the values on `par_m` and `par_n`. With the parallel strobe low during reset, `test_o` is 0.
- R2: While the synchronized `par_strobe` is low (parallel mode), M and N copy `par_m` and `par_n` on every system clock.
- R3: A rising `par_strobe` freezes M and N. Changes on `par_m`/`par_n` have no effect while the strobe stays high.
- R4: While `par_strobe` is high, each rising `ser_clk` shifts `ser_dat` into a 14-bit shift register, first bit first. When `ser_ld` is low and not rising, this shifting leaves M, N and the selector unchanged. The word is decoded as bits 13:12 = selector, 11:9 = N, 8:0 = M. The bits are sent in the order selector high bit, selector low bit, N2..N0, M8..M0. Bits beyond the last 14 fall off the top.
- R5: A rising `ser_ld` (with `par_strobe` high) copies the shift register into the selector, N and M.
- R6: While `ser_ld` stays high, each rising `ser_clk` loads the selector, N and M from the shift register contents that include the new bit.
- R7: After `ser_ld` falls, further serial clocks leave M, N and the selector unchanged.
- R8: With `par_strobe` high, `test_o` follows the selector: 00 gives 0, 01 gives the synchronized `ser_dat`, 10 gives `mdiv_i`, 11 gives `fout_i`.
- R9: In parallel mode, `test_o` is 0 whatever the selector holds.
- R10: `m_bad` is 1 exactly when M is below 250 or above 500.
- R11: A serial load overwrites parallel-latched M and N. A later parallel mode overwrites the serially loaded M and N. The selector can be written only through the serial port, so parallel mode leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high master reset |
| par_strobe | input | 1 | Parallel strobe: low = transparent, rising = latch |
| par_m | input | 9 | Parallel M value |
| par_n | input | 3 | Parallel N code |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_ld | input | 1 | Serial load (asynchronous) |
| mdiv_i | input | 1 | Feedback divider output, for the test pin |
| fout_i | input | 1 | Output clock, for the test pin |
| m_div | output | 9 | Current M setting |
| n_div | output | 3 | Current N code |
| test_o | output | 1 | Test pin |
| m_bad | output | 1 | M outside the lockable range |

## Verification
Several properties are checked on every cycle:
- In parallel mode the settings track the pins one cycle later, and `test_o` is held low.
- The selector never moves in parallel mode.
- A serial load rising edge, or a serial clock while the load is held high, moves the settings to the shift register contents.
- In all other serial-mode cycles the settings stay put.

The bench scenarios show the end-to-end behaviour:
- that the 14-bit framing and bit order land each field where stated, and that overflow bits are dropped;
- that the load-falling freeze holds across later traffic;
- that each selector code routes the right signal;
- that the range flag flips exactly at 249/250 and 500/501.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   typedef enum logic [1:0] {
      TSEL_LOW   = 2'b00,
      TSEL_SDATA = 2'b01,
      TSEL_MDIV  = 2'b10,
      TSEL_FOUT  = 2'b11
   } tsel_e;

   localparam int SYNC_IN_W = 4;
   localparam int IDX_SDAT  = 0;
   localparam int IDX_SCLK  = 1;
   localparam int IDX_SLD   = 2;
   localparam int IDX_PSTB  = 3;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfg_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= {STAGES{RST_VAL}};
         prev  <= RST_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[LAST];
      end
   end

   assign lvl  = chain[LAST];
   assign rise = chain[LAST] & ~prev;
   assign fall = ~chain[LAST] & prev;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
   parameter int FRAME_W = 14
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               shift_en,
   input  logic               bit_in,
   output logic [FRAME_W-1:0] word,
   output logic [FRAME_W-1:0] word_next
);
   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("cfg_shift: FRAME_W must be at least 2");
      end
   endgenerate

   assign word_next = {word[FRAME_W-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (rst)           word <= '0;
      else if (shift_en) word <= word_next;
   end
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
   parameter int M_W = 9,
   parameter int N_W = 3,
   parameter int T_W = 2,
   localparam int FRAME_W = T_W + N_W + M_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               par_mode,
   input  logic [M_W-1:0]     par_m,
   input  logic [N_W-1:0]     par_n,
   input  logic               sld_lvl,
   input  logic               sld_rise,
   input  logic               sclk_rise,
   input  logic [FRAME_W-1:0] sr,
   input  logic [FRAME_W-1:0] sr_next,
   output logic [M_W-1:0]     m_q,
   output logic [N_W-1:0]     n_q,
   output logic [T_W-1:0]     t_q
);
   localparam int M_LSB = 0;
   localparam int N_LSB = M_W;
   localparam int T_LSB = M_W + N_W;

   logic [FRAME_W-1:0] src;
   logic               ser_take;

   always_comb begin
      ser_take = 1'b0;
      src      = sr;
      if (sld_lvl && sclk_rise) begin
         ser_take = 1'b1;
         src      = sr_next;
      end else if (sld_rise) begin
         ser_take = 1'b1;
         src      = sr;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         m_q <= par_m;
         n_q <= par_n;
         t_q <= '0;
      end else if (par_mode) begin
         m_q <= par_m;
         n_q <= par_n;
      end else if (ser_take) begin
         m_q <= src[M_LSB +: M_W];
         n_q <= src[N_LSB +: N_W];
         t_q <= src[T_LSB +: T_W];
      end
   end
endmodule

// File: rtl/cfg_test_sel.sv
module cfg_test_sel #(
   parameter bit TEST_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       par_mode,
   input  logic [1:0] tsel,
   input  logic       sdat,
   input  logic       mdiv,
   input  logic       fout,
   output logic       test_o
);
   import cfg_pkg::*;

   logic pick;

   always_comb begin
      unique case (tsel_e'(tsel))
         TSEL_LOW:   pick = 1'b0;
         TSEL_SDATA: pick = sdat;
         TSEL_MDIV:  pick = mdiv;
         TSEL_FOUT:  pick = fout;
         default:    pick = 1'b0;
      endcase
      if (par_mode) pick = 1'b0;
   end

   generate
      if (TEST_REG) begin : g_reg
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= pick;
         end
         assign test_o = q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst;
         assign test_o = pick;
      end
   endgenerate
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
   parameter int M_W         = 9,
   parameter int N_W         = 3,
   parameter int T_W         = 2,
   parameter int SYNC_STAGES = 2,
   parameter int M_MIN       = 250,
   parameter int M_MAX       = 500,
   parameter bit RANGE_CHECK = 1'b1,
   parameter bit TEST_REG    = 1'b0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           par_strobe,
   input  logic [M_W-1:0] par_m,
   input  logic [N_W-1:0] par_n,
   input  logic           ser_clk,
   input  logic           ser_dat,
   input  logic           ser_ld,
   input  logic           mdiv_i,
   input  logic           fout_i,
   output logic [M_W-1:0] m_div,
   output logic [N_W-1:0] n_div,
   output logic           test_o,
   output logic           m_bad
);
   import cfg_pkg::*;

   localparam int FRAME_W = T_W + N_W + M_W;
   localparam logic [M_W-1:0] M_LO = M_W'(M_MIN);
   localparam logic [M_W-1:0] M_HI = M_W'(M_MAX);

   generate
      if (T_W != 2) begin : g_bad_tw
         $error("synth_cfg_port: the test selector must be 2 bits");
      end
      if (M_MAX >= (1 << M_W) || M_MIN > M_MAX) begin : g_bad_range
         $error("synth_cfg_port: lock range does not fit M_W");
      end
   endgenerate

   logic [SYNC_IN_W-1:0] raw_in;
   logic [SYNC_IN_W-1:0] lvl_v, rise_v, fall_v;

   assign raw_in[IDX_SDAT] = ser_dat;
   assign raw_in[IDX_SCLK] = ser_clk;
   assign raw_in[IDX_SLD]  = ser_ld;
   assign raw_in[IDX_PSTB] = par_strobe;

   generate
      for (genvar i = 0; i < SYNC_IN_W; i++) begin : g_sync
         cfg_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_in[i]),
            .lvl (lvl_v[i]),
            .rise(rise_v[i]),
            .fall(fall_v[i])
         );
      end
   endgenerate

   logic par_lvl, sld_lvl, sld_rise, sclk_rise, sdat_lvl;
   assign par_lvl   = lvl_v[IDX_PSTB];
   assign sld_lvl   = lvl_v[IDX_SLD];
   assign sld_rise  = rise_v[IDX_SLD];
   assign sclk_rise = rise_v[IDX_SCLK];
   assign sdat_lvl  = lvl_v[IDX_SDAT];

   logic unused_edges;
   assign unused_edges = ^{fall_v, rise_v[IDX_SDAT], rise_v[IDX_PSTB], lvl_v[IDX_SCLK]};

   logic [FRAME_W-1:0] sr, sr_next;
   logic [T_W-1:0]     t_val;

   cfg_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .shift_en (par_lvl & sclk_rise),
      .bit_in   (sdat_lvl),
      .word     (sr),
      .word_next(sr_next)
   );

   cfg_store #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_store (
      .clk      (clk),
      .rst      (rst),
      .par_mode (~par_lvl),
      .par_m    (par_m),
      .par_n    (par_n),
      .sld_lvl  (sld_lvl),
      .sld_rise (sld_rise),
      .sclk_rise(sclk_rise),
      .sr       (sr),
      .sr_next  (sr_next),
      .m_q      (m_div),
      .n_q      (n_div),
      .t_q      (t_val)
   );

   cfg_test_sel #(.TEST_REG(TEST_REG)) u_test (
      .clk     (clk),
      .rst     (rst),
      .par_mode(~par_lvl),
      .tsel    (t_val),
      .sdat    (sdat_lvl),
      .mdiv    (mdiv_i),
      .fout    (fout_i),
      .test_o  (test_o)
   );

   generate
      if (RANGE_CHECK) begin : g_range
         assign m_bad = (m_div < M_LO) || (m_div > M_HI);
      end else begin : g_no_range
         assign m_bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cfg_chk.sv
module cfg_chk #(
   parameter int M_W = 9,
   parameter int N_W = 3,
   parameter int T_W = 2,
   localparam int FRAME_W = T_W + N_W + M_W
) (
   input logic               clk,
   input logic               rst,
   input logic               par_lvl,
   input logic               sld_lvl,
   input logic               sld_rise,
   input logic               sclk_rise,
   input logic [M_W-1:0]     par_m,
   input logic [N_W-1:0]     par_n,
   input logic [M_W-1:0]     m_div,
   input logic [N_W-1:0]     n_div,
   input logic [T_W-1:0]     t_val,
   input logic [FRAME_W-1:0] sr,
   input logic [FRAME_W-1:0] sr_next,
   input logic               test_o
);
   // R2
   par_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !par_lvl |=> (m_div == $past(par_m)) && (n_div == $past(par_n)));

   // R9
   par_test_low_chk: assert property (@(posedge clk) disable iff (rst)
      (!par_lvl && !$past(par_lvl)) |-> !test_o);

   // R5
   sload_copy_chk: assert property (@(posedge clk) disable iff (rst)
      (par_lvl && sld_rise && !sclk_rise) |=> ({t_val, n_div, m_div} == $past(sr)));

   // R6
   sload_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (par_lvl && sld_lvl && sclk_rise) |=> ({t_val, n_div, m_div} == $past(sr_next)));

   // R7
   serial_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (par_lvl && !sld_rise && !(sld_lvl && sclk_rise)) |=> $stable({t_val, n_div, m_div}));

   // R11
   tsel_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !par_lvl |=> $stable(t_val));

   // R8
   tsel_low_chk: assert property (@(posedge clk) disable iff (rst)
      (par_lvl && $past(par_lvl) && t_val == '0 && $past(t_val) == '0) |-> !test_o);
endmodule

bind synth_cfg_port cfg_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .par_lvl  (par_lvl),
   .sld_lvl  (sld_lvl),
   .sld_rise (sld_rise),
   .sclk_rise(sclk_rise),
   .par_m    (par_m),
   .par_n    (par_n),
   .m_div    (m_div),
   .n_div    (n_div),
   .t_val    (t_val),
   .sr       (sr),
   .sr_next  (sr_next),
   .test_o   (test_o)
);

// File: tb/sim_synth_cfg_port.sv
module sim_synth_cfg_port;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       par_strobe = 1'b0;
   logic [8:0] par_m = 9'd300;
   logic [2:0] par_n = 3'd5;
   logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
   logic       mdiv_i = 1'b0, fout_i = 1'b0;
   logic [8:0] m_div;
   logic [2:0] n_div;
   logic       test_o, m_bad;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [8:0]  e_m;
   logic [2:0]  e_n;
   logic [1:0]  e_t;
   logic [13:0] e_sr;

   always #5ns clk = ~clk;

   synth_cfg_port u0 (
      .clk(clk), .rst(rst), .par_strobe(par_strobe), .par_m(par_m), .par_n(par_n),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
      .mdiv_i(mdiv_i), .fout_i(fout_i),
      .m_div(m_div), .n_div(n_div), .test_o(test_o), .m_bad(m_bad)
   );

   function automatic bit exp_bad(input logic [8:0] m);
      return (m < 9'd250) || (m > 9'd500);
   endfunction

   function automatic bit exp_test(input logic [1:0] t, input bit pmode,
                                   input bit sd, input bit md, input bit fo);
      if (pmode) return 1'b0;
      case (t)
         2'b00:   return 1'b0;
         2'b01:   return sd;
         2'b10:   return md;
         default: return fo;
      endcase
   endfunction

   task automatic wait_clk(input int k);
      repeat (k) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic check_all(input string req);
      chk({req, " m"}, m_div, e_m);
      chk({req, " n"}, n_div, e_n);
      chk({req, " range"}, m_bad, exp_bad(e_m));
      for (int p = 0; p < 2; p++) begin
         mdiv_i = p[0];
         fout_i = ~p[0];
         #1;
         chk({req, " test"}, test_o,
             exp_test(e_t, !par_strobe, ser_dat, mdiv_i, fout_i));
      end
   endtask

   task automatic par_set(input logic [8:0] m, input logic [2:0] n);
      par_m = m;
      par_n = n;
      wait_clk(2);
      if (!par_strobe) begin
         e_m = m;
         e_n = n;
      end
   endtask

   task automatic strobe(input bit v);
      par_strobe = v;
      wait_clk(6);
      if (!v) begin
         e_m = par_m;
         e_n = par_n;
      end
   endtask

   task automatic send_bit(input bit b);
      ser_dat = b;
      wait_clk(4);
      ser_clk = 1'b1;
      e_sr = {e_sr[12:0], b};
      if (ser_ld) {e_t, e_n, e_m} = e_sr;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
   endtask

   task automatic send_frame(input logic [1:0] t, input logic [2:0] n, input logic [8:0] m);
      logic [13:0] w;
      w = {t, n, m};
      for (int i = 13; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic pulse_load();
      ser_ld = 1'b1;
      wait_clk(6);
      {e_t, e_n, e_m} = e_sr;
      ser_ld = 1'b0;
      wait_clk(6);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd12345));
      e_m = 9'd300; e_n = 3'd5; e_t = 2'b00; e_sr = '0;
      wait_clk(5);
      rst = 1'b0;
      wait_clk(1);
      // R1: reset state
      check_all("R1 reset");

      // R2: parallel transparency, R9: test low in parallel mode
      for (int i = 0; i < 8; i++) begin
         par_set(9'($urandom_range(0, 511)), 3'($urandom_range(0, 7)));
         check_all("R2 R9 parallel follow");
      end

      // R10: range boundaries
      par_set(9'd249, 3'd1); check_all("R10 m=249");
      par_set(9'd250, 3'd1); check_all("R10 m=250");
      par_set(9'd500, 3'd1); check_all("R10 m=500");
      par_set(9'd501, 3'd1); check_all("R10 m=501");
      par_set(9'd0,   3'd1); check_all("R10 m=0");
      par_set(9'd511, 3'd1); check_all("R10 m=511");

      // R3: latch on strobe rise; R1 selector cleared
      par_set(9'd400, 3'd2);
      strobe(1'b1);
      check_all("R1 R3 latched");
      for (int i = 0; i < 4; i++) begin
         par_set(9'($urandom_range(0, 511)), 3'($urandom_range(0, 7)));
         check_all("R3 pins ignored");
      end

      // R4 hold while shifting, R5 load on rise, R11 overwrite
      for (int i = 0; i < 6; i++) begin
         send_frame(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                    9'($urandom_range(0, 511)));
         check_all("R4 shift without load");
         pulse_load();
         check_all("R5 R11 serial load");
      end

      // R8: every selector code
      for (int t = 0; t < 4; t++) begin
         send_frame(2'(t), 3'd3, 9'd333);
         pulse_load();
         for (int d = 0; d < 2; d++) begin
            ser_dat = d[0];
            wait_clk(6);
            check_all("R8 test select");
         end
      end

      // R4: overflow bits discarded
      for (int i = 0; i < 17; i++) send_bit(1'($urandom_range(0, 1)));
      pulse_load();
      check_all("R4 overflow");

      // R6: load held high follows each shift
      ser_ld = 1'b1;
      wait_clk(6);
      {e_t, e_n, e_m} = e_sr;
      check_all("R6 hold-high entry");
      for (int i = 0; i < 14; i++) begin
         send_bit(1'($urandom_range(0, 1)));
         check_all("R6 follow shift");
      end

      // R7: freeze after load falls
      ser_ld = 1'b0;
      wait_clk(6);
      for (int i = 0; i < 5; i++) begin
         send_bit(1'($urandom_range(0, 1)));
         check_all("R7 frozen");
      end

      // R11: parallel overrides serial M/N, selector kept
      send_frame(2'b10, 3'd6, 9'd260);
      pulse_load();
      check_all("R11 serial set");
      par_m = 9'd444; par_n = 3'd4;
      strobe(1'b0);
      check_all("R11 parallel override");
      strobe(1'b1);
      check_all("R11 selector kept");

      // mixed random traffic
      for (int i = 0; i < 40; i++) begin
         case ($urandom_range(0, 3))
            0: begin
               send_frame(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                          9'($urandom_range(0, 511)));
               pulse_load();
               check_all("R5 random load");
            end
            1: begin
               send_bit(1'($urandom_range(0, 1)));
               check_all("R4 random shift");
            end
            2: begin
               par_m = 9'($urandom_range(0, 511));
               par_n = 3'($urandom_range(0, 7));
               strobe(1'b0);
               check_all("R2 random parallel");
               strobe(1'b1);
               check_all("R3 random latch");
            end
            default: begin
               ser_dat = 1'($urandom_range(0, 1));
               wait_clk(6);
               check_all("R8 random probe");
            end
         endcase
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule